// File: doc/BRIEF.md
# I2C Slave Buffer Transaction Sequencer

This block is the byte-level decision logic that sits behind an I2C slave bit shifter and exposes memory to a bus master. The shifter reports four kinds of event: a received address byte, a received data byte, a request for the next transmit byte, and a stop or reset. The block answers each received byte with ACK or NAK and supplies the byte the shifter sends next. It drives a synchronous read/write port to a buffer memory and a synchronous read-only port. The read-only port is reached when the master sets the alternate-select bit of the address.

A write transaction begins with an offset byte. The block saves that offset and also loads it into an auto-incrementing pointer. Later data bytes fill the buffer up to a separate writable limit. Every read transaction restarts at the saved offset and steps through the buffer. When the pointer runs past the buffer size, the last byte is sent again. The read-only region works the same way but has its own size, offset and pointer. It is addressed as a 16-bit base plus the pointer. Two sticky flags record read and write activity until the host clears them.

Top module: `i2cbt_seq`

## Requirements
- R1: In an address byte, bit 0 is the direction (1 = read) and bit 7 is the alternate-select bit. The remaining bits [6:1] are compared with `cfg_dev_addr[5:0]`. On a mismatch the block answers NAK (`resp_valid`=1, `resp_ack`=0) in the cycle after the event, and then NAKs data bytes as an idle slave.
- R2: After a matching write address (ACK), the first data byte is an offset. If the offset is greater than or equal to the buffer size, it is NAKed and the block waits for another offset. If it is smaller, it is ACKed and loads both the saved offset and the pointer.
- R3: Each later data byte is stored at the pointer, the pointer increments, and the byte is ACKed, but only while the pointer is below the writable size. Any other data byte is NAKed and not stored. A writable size of zero NAKs every data byte.
- R4: A matching read address is ACKed with `resp_tx`=1. The first transmit byte is read from the saved offset, and the pointer moves to offset+1.
- R5: Each `ev_next` loads the byte at the pointer and advances it, while the pointer is below the buffer size. Beyond that, the previous byte is kept and the pointer does not move.
- R6: `tx_ready` is low in the cycle after a fetch starts. It is high, with the fetched byte on `tx_byte`, in the cycle after that.
- R7: With the alternate-select bit set, the offset is checked against the read-only size. Reads come from `cfg_ro_base` plus the read-only pointer, as a 16-bit sum in which the carry reaches the high byte.
- R8: Data bytes sent after a read-only offset are NAKed.
- R9: A stop or reset event returns the block to idle. Saved offsets are kept, so the next read starts where the last offset pointed.
- R10: `act_flags[0]` (read: a fetch on `ev_next` from the buffer) and `act_flags[1]` (write: a stored byte) stay set until an `act_clr` pulse. If a set and the clear fall in the same cycle, the flag stays set.
- R11: The buffer size, writable size and read-only base are sampled at the address event. Changing them later in the transaction has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_addr | input | 1 | Address byte received (with rx_byte) |
| ev_data | input | 1 | Data byte received (with rx_byte) |
| ev_next | input | 1 | Master requests the next transmit byte |
| ev_stop | input | 1 | Stop condition seen |
| ev_reset | input | 1 | Bus reset event |
| rx_byte | input | DW | Received byte |
| cfg_dev_addr | input | 7 | Own 7-bit slave address |
| cfg_buf_size | input | PW | Buffer size in bytes |
| cfg_wr_size | input | PW | Writable byte count |
| cfg_ro_size | input | PW | Read-only region size |
| cfg_ro_base | input | RAW | Read-only region base address |
| resp_valid | output | 1 | Response to an address/data byte is valid |
| resp_ack | output | 1 | 1 = ACK, 0 = NAK |
| resp_tx | output | 1 | Switch the shifter to transmit |
| tx_byte | output | DW | Byte to transmit |
| tx_ready | output | 1 | tx_byte holds a valid fetched byte |
| ram_en | output | 1 | Buffer port enable |
| ram_we | output | 1 | Buffer port write strobe |
| ram_addr | output | PW | Buffer port address |
| ram_wdata | output | DW | Buffer write data |
| ram_rdata | input | DW | Buffer read data, one cycle after ram_en |
| rom_en | output | 1 | Read-only port enable |
| rom_addr | output | RAW | Read-only port address |
| rom_rdata | input | DW | Read-only data, one cycle after rom_en |
| act_clr | input | 1 | Clears both activity flags |
| act_flags | output | 2 | [0] read activity, [1] write activity |

## Verification
Address bytes are sent that differ in the masked bits, in the direction bit and in the alternate-select bit, to show that only the compared field decides whether the slave answers. Offsets are chosen equal to the size and one below it, and writes run up to the writable limit and then pass it or use a zero limit, so the range checks are probed on both sides of each edge. Reads run past the buffer end to separate advancing from repeating. A read-only base near a 256-byte boundary shows whether the carry reaches the high byte. Configuration inputs change in the middle of a transaction, and a set and a clear arrive in the same cycle, to confirm sampling and priority.

// File: rtl/i2cbt_pkg.sv
package i2cbt_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RW_OFS,
      ST_RW_DATA,
      ST_RW_READ,
      ST_RO_OFS,
      ST_RO_DATA,
      ST_RO_READ
   } seq_state_t;

   typedef enum logic [1:0] {
      SRC_NONE,
      SRC_RW,
      SRC_RO
   } fetch_src_t;

   localparam int unsigned ACT_RD = 0;
   localparam int unsigned ACT_WR = 1;
   localparam int unsigned ACT_N  = 2;

endpackage

// File: rtl/i2cbt_addr_match.sv
module i2cbt_addr_match #(
   parameter int unsigned DW      = 8,
   parameter int unsigned ALT_BIT = 7,
   parameter bit          RO_EN   = 1'b1
) (
   input  logic [DW-1:0] rx_byte,
   input  logic [6:0]    dev_addr,
   output logic          hit,
   output logic          alt,
   output logic          rd
);

   localparam logic [7:0] ALT_MASK = 8'(1) << ALT_BIT;
   logic [7:0] expect_byte;
   logic [7:0] cmp_mask;

   assign expect_byte = {dev_addr, 1'b0};
   assign rd          = rx_byte[0];

   generate
      if (RO_EN) begin : g_alt_on
         assign cmp_mask = ~(ALT_MASK | 8'h01);
         assign alt      = rx_byte[ALT_BIT];
      end else begin : g_alt_off
         assign cmp_mask = 8'hFE;
         assign alt      = 1'b0;
      end
   endgenerate

   assign hit = ((rx_byte[7:0] ^ expect_byte) & cmp_mask) == 8'h00;

endmodule

// File: rtl/i2cbt_ptr_unit.sv
module i2cbt_ptr_unit #(
   parameter int unsigned PW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [PW-1:0] load_val,
   input  logic          rewind,
   input  logic          step,
   output logic [PW-1:0] ofs,
   output logic [PW-1:0] ptr
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ofs <= '0;
         ptr <= '0;
      end else if (load) begin
         ofs <= load_val;
         ptr <= load_val;
      end else if (rewind) begin
         ptr <= ofs + PW'(1);
      end else if (step) begin
         ptr <= ptr + PW'(1);
      end
   end

   AST_REWIND_FROM_OFS: assert property (@(posedge clk) disable iff (!rst_n)
      (rewind && !load) |=> (ptr == $past(ofs) + PW'(1)))
      else $error("rewind did not restart at saved offset"); // R4

endmodule

// File: rtl/i2cbt_flag_bank.sv
module i2cbt_flag_bank #(
   parameter int unsigned N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic         clr,
   output logic [N-1:0] flags
);

   generate
      for (genvar i = 0; i < N; i++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      flags[i] <= 1'b0;
            else if (set[i]) flags[i] <= 1'b1;
            else if (clr)    flags[i] <= 1'b0;
         end

         AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> flags[i])
            else $error("activity flag not set"); // R10

         AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && !clr) |=> flags[i])
            else $error("activity flag dropped without clear"); // R10
      end
   endgenerate

endmodule

// File: rtl/i2cbt_seq.sv
module i2cbt_seq
   import i2cbt_pkg::*;
#(
   parameter int unsigned DW      = 8,
   parameter int unsigned PW      = 8,
   parameter int unsigned RAW     = 16,
   parameter int unsigned ALT_BIT = 7,
   parameter bit          RO_EN   = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ev_addr,
   input  logic           ev_data,
   input  logic           ev_next,
   input  logic           ev_stop,
   input  logic           ev_reset,
   input  logic [DW-1:0]  rx_byte,
   input  logic [6:0]     cfg_dev_addr,
   input  logic [PW-1:0]  cfg_buf_size,
   input  logic [PW-1:0]  cfg_wr_size,
   input  logic [PW-1:0]  cfg_ro_size,
   input  logic [RAW-1:0] cfg_ro_base,
   output logic           resp_valid,
   output logic           resp_ack,
   output logic           resp_tx,
   output logic [DW-1:0]  tx_byte,
   output logic           tx_ready,
   output logic           ram_en,
   output logic           ram_we,
   output logic [PW-1:0]  ram_addr,
   output logic [DW-1:0]  ram_wdata,
   input  logic [DW-1:0]  ram_rdata,
   output logic           rom_en,
   output logic [RAW-1:0] rom_addr,
   input  logic [DW-1:0]  rom_rdata,
   input  logic           act_clr,
   output logic [1:0]     act_flags
);

   initial begin
      assert (DW == 8) else $fatal(1, "DW must be 8 for I2C bytes");
      assert (PW >= 1 && PW <= DW) else $fatal(1, "PW out of range");
      assert (RAW >= PW && RAW <= 32) else $fatal(1, "RAW out of range");
      assert (ALT_BIT >= 1 && ALT_BIT <= 7) else $fatal(1, "ALT_BIT out of range");
   end

   seq_state_t state, st_nx;
   fetch_src_t fetch_src, src_nx;

   logic a_hit, a_alt, a_rd;
   logic kill;
   logic rsp_v_nx, rsp_a_nx, rsp_t_nx;
   logic [PW-1:0]  cur_size, cur_wsize, cur_rosize;
   logic [RAW-1:0] cur_base;
   logic smp_cfg;
   logic rw_load, rw_rew, rw_step, ro_load, ro_rew, ro_step;
   logic [PW-1:0] rw_ofs, rw_ptr, ro_ofs, ro_ptr;
   logic [ACT_N-1:0] act_set;
   logic ofs_in_rw, ofs_in_ro, wr_ok, more_rw, more_ro;

   i2cbt_addr_match #(.DW(DW), .ALT_BIT(ALT_BIT), .RO_EN(RO_EN)) u_match (
      .rx_byte (rx_byte),
      .dev_addr(cfg_dev_addr),
      .hit     (a_hit),
      .alt     (a_alt),
      .rd      (a_rd)
   );

   i2cbt_ptr_unit #(.PW(PW)) u_rw_ptr (
      .clk(clk), .rst_n(rst_n),
      .load(rw_load), .load_val(rx_byte[PW-1:0]),
      .rewind(rw_rew), .step(rw_step),
      .ofs(rw_ofs), .ptr(rw_ptr)
   );

   i2cbt_ptr_unit #(.PW(PW)) u_ro_ptr (
      .clk(clk), .rst_n(rst_n),
      .load(ro_load), .load_val(rx_byte[PW-1:0]),
      .rewind(ro_rew), .step(ro_step),
      .ofs(ro_ofs), .ptr(ro_ptr)
   );

   i2cbt_flag_bank #(.N(ACT_N)) u_flags (
      .clk(clk), .rst_n(rst_n),
      .set(act_set), .clr(act_clr),
      .flags(act_flags)
   );

   assign kill      = ev_stop | ev_reset;
   assign ofs_in_rw = 32'(rx_byte) < 32'(cur_size);
   assign ofs_in_ro = 32'(rx_byte) < 32'(cur_rosize);
   assign wr_ok     = 32'(rw_ptr) < 32'(cur_wsize);
   assign more_rw   = 32'(rw_ptr) < 32'(cur_size);
   assign more_ro   = 32'(ro_ptr) < 32'(cur_rosize);

   always_comb begin
      st_nx     = state;
      src_nx    = SRC_NONE;
      rsp_v_nx  = 1'b0;
      rsp_a_nx  = 1'b0;
      rsp_t_nx  = 1'b0;
      smp_cfg   = 1'b0;
      ram_en    = 1'b0;
      ram_we    = 1'b0;
      ram_addr  = rw_ptr;
      ram_wdata = rx_byte;
      rom_en    = 1'b0;
      rom_addr  = cur_base + RAW'(ro_ptr);
      rw_load   = 1'b0;
      rw_rew    = 1'b0;
      rw_step   = 1'b0;
      ro_load   = 1'b0;
      ro_rew    = 1'b0;
      ro_step   = 1'b0;
      act_set   = '0;
      if (kill) begin
         st_nx = ST_IDLE;
      end else if (ev_addr) begin
         smp_cfg  = 1'b1;
         rsp_v_nx = 1'b1;
         if (!a_hit) begin
            st_nx = ST_IDLE;
         end else begin
            rsp_a_nx = 1'b1;
            if (a_alt && a_rd) begin
               st_nx    = ST_RO_READ;
               rsp_t_nx = 1'b1;
               rom_en   = 1'b1;
               rom_addr = cfg_ro_base + RAW'(ro_ofs);
               ro_rew   = 1'b1;
               src_nx   = SRC_RO;
            end else if (a_alt) begin
               st_nx = ST_RO_OFS;
            end else if (a_rd) begin
               st_nx    = ST_RW_READ;
               rsp_t_nx = 1'b1;
               ram_en   = 1'b1;
               ram_addr = rw_ofs;
               rw_rew   = 1'b1;
               src_nx   = SRC_RW;
            end else begin
               st_nx = ST_RW_OFS;
            end
         end
      end else if (ev_data) begin
         rsp_v_nx = 1'b1;
         case (state)
            ST_RW_OFS: begin
               if (ofs_in_rw) begin
                  rw_load  = 1'b1;
                  st_nx    = ST_RW_DATA;
                  rsp_a_nx = 1'b1;
               end
            end
            ST_RW_DATA: begin
               if (wr_ok) begin
                  ram_en          = 1'b1;
                  ram_we          = 1'b1;
                  rw_step         = 1'b1;
                  act_set[ACT_WR] = 1'b1;
                  rsp_a_nx        = 1'b1;
               end
            end
            ST_RO_OFS: begin
               if (ofs_in_ro) begin
                  ro_load  = 1'b1;
                  st_nx    = ST_RO_DATA;
                  rsp_a_nx = 1'b1;
               end
            end
            default: ;
         endcase
      end else if (ev_next && tx_ready) begin
         if (state == ST_RW_READ && more_rw) begin
            ram_en          = 1'b1;
            rw_step         = 1'b1;
            act_set[ACT_RD] = 1'b1;
            src_nx          = SRC_RW;
         end else if (state == ST_RO_READ && more_ro) begin
            rom_en  = 1'b1;
            ro_step = 1'b1;
            src_nx  = SRC_RO;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         fetch_src  <= SRC_NONE;
         resp_valid <= 1'b0;
         resp_ack   <= 1'b0;
         resp_tx    <= 1'b0;
         tx_byte    <= '0;
         tx_ready   <= 1'b0;
         cur_size   <= '0;
         cur_wsize  <= '0;
         cur_rosize <= '0;
         cur_base   <= '0;
      end else begin
         state      <= st_nx;
         fetch_src  <= src_nx;
         resp_valid <= rsp_v_nx;
         resp_ack   <= rsp_a_nx;
         resp_tx    <= rsp_t_nx;
         if (smp_cfg) begin
            cur_size   <= cfg_buf_size;
            cur_wsize  <= cfg_wr_size;
            cur_rosize <= cfg_ro_size;
            cur_base   <= cfg_ro_base;
         end
         if (fetch_src == SRC_RW)      tx_byte <= ram_rdata;
         else if (fetch_src == SRC_RO) tx_byte <= rom_rdata;
         if (src_nx != SRC_NONE)         tx_ready <= 1'b0;
         else if (fetch_src != SRC_NONE) tx_ready <= 1'b1;
      end
   end

   AST_ADDR_MISS_NAK: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_addr && !kill && !a_hit) |=> (resp_valid && !resp_ack && !resp_tx))
      else $error("mismatched address not NAKed"); // R1

   AST_WR_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> (32'(ram_addr) < 32'(cur_wsize)))
      else $error("write beyond writable size"); // R3

   AST_FETCH_HIDES: assert property (@(posedge clk) disable iff (!rst_n)
      ((ram_en && !ram_we) || rom_en) |=> !tx_ready)
      else $error("tx_ready high during fetch"); // R6

   AST_FETCH_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_src != SRC_NONE && src_nx == SRC_NONE) |=> tx_ready)
      else $error("fetched byte not presented"); // R6

   AST_RO_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RO_DATA && ev_data && !ev_addr && !kill) |=> (resp_valid && !resp_ack))
      else $error("read-only data byte ACKed"); // R8

   AST_RO_NO_RAM: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RO_READ || state == ST_RO_DATA) |-> !ram_we)
      else $error("buffer written from read-only region"); // R7

   AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      kill |=> (state == ST_IDLE))
      else $error("stop did not return to idle"); // R9

endmodule

// File: tb/i2cbt_seq_tb.sv
module i2cbt_seq_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ev_addr = 0, ev_data = 0, ev_next = 0, ev_stop = 0, ev_reset = 0;
   logic [7:0]  rx_byte = '0;
   logic [6:0]  cfg_dev_addr = 7'h2A;
   logic [7:0]  cfg_buf_size = 8'd16, cfg_wr_size = 8'd8, cfg_ro_size = 8'd200;
   logic [15:0] cfg_ro_base = 16'h12F0;
   logic        resp_valid, resp_ack, resp_tx, tx_ready;
   logic [7:0]  tx_byte;
   logic        ram_en, ram_we, rom_en;
   logic [7:0]  ram_addr, ram_wdata;
   logic [7:0]  ram_rdata = '0, rom_rdata = '0;
   logic [15:0] rom_addr;
   logic        act_clr = 1'b0;
   logic [1:0]  act_flags;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   logic [7:0] mem [256];

   always #2 clk = ~clk;

   i2cbt_seq dut_i (
      .clk(clk), .rst_n(rst_n),
      .ev_addr(ev_addr), .ev_data(ev_data), .ev_next(ev_next),
      .ev_stop(ev_stop), .ev_reset(ev_reset), .rx_byte(rx_byte),
      .cfg_dev_addr(cfg_dev_addr), .cfg_buf_size(cfg_buf_size),
      .cfg_wr_size(cfg_wr_size), .cfg_ro_size(cfg_ro_size),
      .cfg_ro_base(cfg_ro_base),
      .resp_valid(resp_valid), .resp_ack(resp_ack), .resp_tx(resp_tx),
      .tx_byte(tx_byte), .tx_ready(tx_ready),
      .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
      .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
      .rom_en(rom_en), .rom_addr(rom_addr), .rom_rdata(rom_rdata),
      .act_clr(act_clr), .act_flags(act_flags)
   );

   function automatic logic [7:0] rom_val(input logic [15:0] a);
      return a[7:0] ^ a[15:8] ^ 8'h5A;
   endfunction

   function automatic logic [7:0] init_val(input int i);
      return 8'(8'h40 + i);
   endfunction

   always @(posedge clk) begin
      if (ram_en && ram_we) mem[ram_addr] <= ram_wdata;
      else if (ram_en)      ram_rdata <= mem[ram_addr];
      if (rom_en)           rom_rdata <= rom_val(rom_addr);
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic pulse_addr(input logic [7:0] b);
      @(negedge clk); ev_addr = 1'b1; rx_byte = b;
      @(negedge clk); ev_addr = 1'b0;
   endtask

   task automatic pulse_data(input logic [7:0] b);
      @(negedge clk); ev_data = 1'b1; rx_byte = b;
      @(negedge clk); ev_data = 1'b0;
   endtask

   task automatic send_stop();
      @(negedge clk); ev_stop = 1'b1;
      @(negedge clk); ev_stop = 1'b0;
   endtask

   task automatic clear_flags();
      @(negedge clk); act_clr = 1'b1;
      @(negedge clk); act_clr = 1'b0;
   endtask

   // response is visible at the negedge right after the event edge
   task automatic expect_resp(input string req, input logic ack, input logic tx);
      check(req, {resp_valid, resp_ack, resp_tx}, {1'b1, ack, tx});
   endtask

   task automatic read_start(input string req, input logic [7:0] b, input logic [7:0] exp);
      pulse_addr(b);
      expect_resp(req, 1'b1, 1'b1);
      check("R6 tx_ready low after launch", tx_ready, 1'b0);
      @(negedge clk);
      check("R6 tx_ready high with byte", tx_ready, 1'b1);
      check(req, tx_byte, exp);
   endtask

   task automatic next_byte(input string req, input logic [7:0] exp);
      @(negedge clk); ev_next = 1'b1;
      @(negedge clk); ev_next = 1'b0;
      @(negedge clk);
      check(req, {tx_ready, tx_byte}, {1'b1, exp});
   endtask

   task automatic t_reset();
      check("R6 reset tx_ready", tx_ready, 1'b0);
      check("R10 reset flags", act_flags, 2'b00);
      check("R1 reset resp_valid", resp_valid, 1'b0);
   endtask

   task automatic t_mismatch();
      pulse_addr(8'h56);
      expect_resp("R1 mismatched address NAK", 1'b0, 1'b0);
      pulse_data(8'h00);
      expect_resp("R1 idle data NAK", 1'b0, 1'b0);
   endtask

   task automatic t_write();
      pulse_addr(8'h54);
      expect_resp("R2 write address ACK", 1'b1, 1'b0);
      pulse_data(8'd16);
      expect_resp("R2 offset equal to size NAK", 1'b0, 1'b0);
      pulse_data(8'd4);
      expect_resp("R2 offset in range ACK", 1'b1, 1'b0);
      for (int i = 4; i < 8; i++) begin
         pulse_data(8'(8'hA0 + i));
         expect_resp("R3 in-range data ACK", 1'b1, 1'b0);
      end
      pulse_data(8'hA8);
      expect_resp("R3 data at writable limit NAK", 1'b0, 1'b0);
      @(negedge clk);
      check("R3 stored byte 4", mem[4], 8'hA4);
      check("R3 stored byte 7", mem[7], 8'hA7);
      check("R3 byte past limit untouched", mem[8], init_val(8));
      check("R10 write flag set", act_flags[1], 1'b1);
      check("R10 read flag still clear", act_flags[0], 1'b0);
      clear_flags();
      check("R10 flags cleared", act_flags, 2'b00);
      send_stop();
   endtask

   task automatic t_read();
      read_start("R4 first byte from saved offset", 8'h55, 8'hA4);
      for (int i = 5; i < 16; i++)
         next_byte("R5 advancing read", (i < 8) ? 8'(8'hA0 + i) : init_val(i));
      next_byte("R5 repeat past end", init_val(15));
      next_byte("R5 repeat again", init_val(15));
      check("R10 read flag set", act_flags[0], 1'b1);
      send_stop();
   endtask

   task automatic t_stop();
      pulse_data(8'h11);
      expect_resp("R9 data after stop NAK", 1'b0, 1'b0);
      read_start("R9 offset kept across stop", 8'h55, 8'hA4);
      @(negedge clk); ev_reset = 1'b1;
      @(negedge clk); ev_reset = 1'b0;
      pulse_data(8'h12);
      expect_resp("R9 data after reset event NAK", 1'b0, 1'b0);
   endtask

   task automatic t_sample();
      pulse_addr(8'h54);
      pulse_data(8'd10);
      expect_resp("R11 offset ACK", 1'b1, 1'b0);
      send_stop();
      cfg_buf_size = 8'd12;
      read_start("R11 read at offset 10", 8'h55, init_val(10));
      cfg_buf_size = 8'd255;
      next_byte("R11 read at 11", init_val(11));
      next_byte("R11 size sampled, repeat", init_val(11));
      send_stop();
      cfg_buf_size = 8'd16;
   endtask

   task automatic t_zero_wsize();
      cfg_wr_size = 8'd0;
      pulse_addr(8'h54);
      pulse_data(8'd2);
      expect_resp("R3 offset ACK with zero writable", 1'b1, 1'b0);
      pulse_data(8'h77);
      expect_resp("R3 zero writable size NAK", 1'b0, 1'b0);
      @(negedge clk);
      check("R3 zero size no store", mem[2], init_val(2));
      send_stop();
      cfg_wr_size = 8'd8;
   endtask

   task automatic t_ro();
      pulse_addr(8'hD4);
      expect_resp("R7 alt write address ACK", 1'b1, 1'b0);
      pulse_data(8'd200);
      expect_resp("R7 offset equal to ro size NAK", 1'b0, 1'b0);
      pulse_data(8'h20);
      expect_resp("R7 ro offset ACK", 1'b1, 1'b0);
      pulse_data(8'h99);
      expect_resp("R8 ro data NAK", 1'b0, 1'b0);
      send_stop();
      read_start("R7 ro first byte with carry", 8'hD5, rom_val(16'h1310));
      next_byte("R7 ro next byte", rom_val(16'h1311));
      send_stop();
      check("R7 buffer untouched by ro", mem[2], init_val(2));
   endtask

   task automatic t_set_wins();
      clear_flags();
      pulse_addr(8'h54);
      pulse_data(8'd4);
      @(negedge clk); ev_data = 1'b1; rx_byte = 8'hB4; act_clr = 1'b1;
      @(negedge clk); ev_data = 1'b0; act_clr = 1'b0;
      expect_resp("R10 data ACK", 1'b1, 1'b0);
      check("R10 set wins over clear", act_flags[1], 1'b1);
      send_stop();
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = init_val(i);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mismatch();
      t_write();
      t_read();
      t_stop();
      t_sample();
      t_zero_wsize();
      t_ro();
      t_set_wins();
      done = 1'b1;
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

endmodule